// File: doc/BRIEF.md
# Banked Internal Data RAM with Bit Access and Hardware Stack

This block is the 128-byte internal data store of a small 8-bit controller. One storage array serves four kinds of request. The first is plain byte access by address. The second is access to working registers through a selected bank of eight. The third is single-bit read, set and clear over a sixteen-byte window. The fourth is a hardware stack that grows upward from a pointer held inside the block.

Each request is one transfer on a valid/ready command channel. The block carries the operation code, an address (byte address, register index or bit number) and write data. Each accepted request produces exactly one result on a valid/ready response channel. There is one response buffer, so a new request is accepted only when that buffer is empty or is being emptied in the same cycle. When the consumer holds `rsp_ready` low, back-pressure stalls the command side and the pending result stays frozen.

The stack pointer and a one-cycle overflow pulse are plain status outputs.

Top module: `iram_core`

## Requirements
- R1: After reset, `sp_out` is 0x07, the active bank is 0, `rsp_valid` is low and `sp_ovf` is low.
- R2: Op 0 (byte read) returns the byte at `req_addr`. Op 1 (byte write) stores `req_wdata` there and echoes it. This covers any address 0x00–0x7F, and each result is presented in the cycle after acceptance.
- R3: Op 9 latches `bank_sel` as the active bank and returns it zero-extended. Op 2 (register read) and op 3 (register write, echoing data) reach the byte at address bank×8 + `req_addr[2:0]`.
- R4: Op 4 (bit read) returns 0x01 or 0x00. The value is bit (n & 7) of byte 0x20 + (n >> 3), where n is `req_addr`. For example, bit 0x25 is bit 5 of byte 0x24.
- R5: Op 5 (bit set) and op 6 (bit clear) change only the addressed bit of its byte, leave the other seven bits as they were, and return the updated byte.
- R6: Op 7 (push) first increments the pointer. It then stores `req_wdata` at the new pointer value and echoes the data, so the first push after reset writes address 0x08.
- R7: Op 8 (pop) returns the byte at the current pointer and then decrements the pointer.
- R8: The pointer counts modulo 128. A push at 0x7F writes address 0x00 and raises `sp_ovf` for exactly the one cycle in which its result appears. A pop at 0x00 leaves the pointer at 0x7F without a pulse.
- R9: Op codes 10–15 change neither storage nor the pointer, and return 0x00.
- R10: A request is taken when `req_valid` and `req_ready` are both high. `req_ready` is low only while a result is held with `rsp_ready` low. During that stall `rsp_valid` stays high and `rsp_data` stays unchanged.
- R11: Only byte, register, bit-set/clear and push operations change storage, and the pointer changes only on push and pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Command present |
| req_ready | output | 1 | Command can be taken this cycle |
| req_op | input | 4 | Operation code (0–9 defined) |
| req_addr | input | 7 | Byte address, register index in [2:0], or bit number |
| req_wdata | input | 8 | Data for writes and pushes |
| bank_sel | input | 2 | Bank number captured by op 9 |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_data | output | 8 | Result byte |
| sp_out | output | 8 | Current stack pointer, upper bit zero |
| sp_ovf | output | 1 | One-cycle pulse on push past 0x7F |

## Verification
Every operation settles at the rising edge that accepts it. That single edge updates the storage, the pointer, the response register and the overflow pulse, so all results become visible one edge after acceptance. Each directed task drives its command on a falling edge and lets one rising edge pass. It then reads `rsp_data`, `sp_out` and `sp_ovf` on the following falling edge, and later tasks read back storage to confirm side effects. The stall scenario holds `rsp_ready` low for several falling-edge samples before releasing it. It then expects the queued command's result exactly one edge after the release.

// File: rtl/iram_pkg.sv
package iram_pkg;
  typedef enum logic [3:0] {
    OP_RD_BYTE = 4'd0,
    OP_WR_BYTE = 4'd1,
    OP_RD_REG  = 4'd2,
    OP_WR_REG  = 4'd3,
    OP_BIT_RD  = 4'd4,
    OP_BIT_SET = 4'd5,
    OP_BIT_CLR = 4'd6,
    OP_PUSH    = 4'd7,
    OP_POP     = 4'd8,
    OP_BANK    = 4'd9
  } op_e;
endpackage

// File: rtl/iram_addr_map.sv
module iram_addr_map import iram_pkg::*; #(
  parameter int ADDR_W   = 7,
  parameter int BANK_W   = 2,
  parameter int REG_W    = 3,
  parameter int BIT_BASE = 32
) (
  input  op_e               op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BANK_W-1:0] bank,
  input  logic [ADDR_W-1:0] sp,
  output logic [ADDR_W-1:0] phys,
  output logic [2:0]        bit_pos
);
  localparam int PAD_W = ADDR_W - BANK_W - REG_W;
  localparam int OFS_W = ADDR_W - 3;
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BIT_BASE);

  logic [ADDR_W-1:0] reg_addr;
  logic [ADDR_W-1:0] bit_byte;

  assign reg_addr = {{PAD_W{1'b0}}, bank, addr[REG_W-1:0]};
  assign bit_byte = BASE + {3'b000, addr[ADDR_W-1:3]};
  assign bit_pos  = addr[2:0];

  always_comb begin
    unique case (op)
      OP_RD_REG, OP_WR_REG:            phys = reg_addr;
      OP_BIT_RD, OP_BIT_SET, OP_BIT_CLR: phys = bit_byte;
      OP_PUSH:                         phys = sp + ADDR_W'(1);
      OP_POP:                          phys = sp;
      default:                         phys = addr;
    endcase
  end

  logic [OFS_W-1:0] unused_ofs;
  assign unused_ofs = '0;
endmodule

// File: rtl/iram_store.sv
module iram_store #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  assign rdata = mem[addr];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end
endmodule

// File: rtl/iram_stack_ptr.sv
module iram_stack_ptr #(
  parameter int ADDR_W   = 7,
  parameter int SP_RESET = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  output logic [ADDR_W-1:0] sp,
  output logic              ovf
);
  localparam logic [ADDR_W-1:0] SP_TOP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp  <= ADDR_W'(SP_RESET);
      ovf <= 1'b0;
    end else begin
      ovf <= push && (sp == SP_TOP);
      if (push)     sp <= sp + ADDR_W'(1);
      else if (pop) sp <= sp - ADDR_W'(1);
    end
  end
endmodule

// File: rtl/iram_core.sv
module iram_core import iram_pkg::*; #(
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 8,
  parameter int BANK_W   = 2,
  parameter int REG_W    = 3,
  parameter int BIT_BASE = 32,
  parameter int SP_RESET = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [3:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [BANK_W-1:0] bank_sel,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic [DATA_W-1:0] sp_out,
  output logic              sp_ovf
);
  localparam int SP_PAD = DATA_W - ADDR_W;

  op_e               op;
  logic              take;
  logic [BANK_W-1:0] bank_q;
  logic [ADDR_W-1:0] sp;
  logic [ADDR_W-1:0] phys;
  logic [2:0]        bit_pos;
  logic [DATA_W-1:0] rdata;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] wr_byte;
  logic [DATA_W-1:0] result;
  logic              we;

  assign op        = op_e'(req_op);
  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;
  assign mask      = DATA_W'(1) << bit_pos;
  assign sp_out    = {{SP_PAD{1'b0}}, sp};

  iram_addr_map #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .REG_W(REG_W), .BIT_BASE(BIT_BASE)
  ) u_map (
    .op(op), .addr(req_addr), .bank(bank_q), .sp(sp),
    .phys(phys), .bit_pos(bit_pos)
  );

  iram_stack_ptr #(.ADDR_W(ADDR_W), .SP_RESET(SP_RESET)) u_sp (
    .clk(clk), .rst_n(rst_n),
    .push(take && op == OP_PUSH), .pop(take && op == OP_POP),
    .sp(sp), .ovf(sp_ovf)
  );

  iram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .addr(phys), .we(take && we), .wdata(wr_byte), .rdata(rdata)
  );

  always_comb begin
    we      = 1'b0;
    wr_byte = req_wdata;
    result  = '0;
    unique case (op)
      OP_RD_BYTE, OP_RD_REG, OP_POP: result = rdata;
      OP_WR_BYTE, OP_WR_REG, OP_PUSH: begin
        we     = 1'b1;
        result = req_wdata;
      end
      OP_BIT_RD:  result = DATA_W'(rdata[bit_pos]);
      OP_BIT_SET: begin
        we      = 1'b1;
        wr_byte = rdata | mask;
        result  = wr_byte;
      end
      OP_BIT_CLR: begin
        we      = 1'b1;
        wr_byte = rdata & ~mask;
        result  = wr_byte;
      end
      OP_BANK:    result = DATA_W'(bank_sel);
      default:    result = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      if (take && op == OP_BANK) bank_q <= bank_sel;
      if (take) begin
        rsp_valid <= 1'b1;
        rsp_data  <= result;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/iram_core_chk.sv
module iram_core_chk #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [3:0]        req_op,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic [DATA_W-1:0] sp_out,
  input logic              sp_ovf
);
  logic acc;
  assign acc = req_valid && req_ready;

  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_op == 4'd7) |=> sp_out[ADDR_W-1:0] == $past(sp_out[ADDR_W-1:0]) + ADDR_W'(1)); // R6

  AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_op == 4'd8) |=> sp_out[ADDR_W-1:0] == $past(sp_out[ADDR_W-1:0]) - ADDR_W'(1)); // R7

  AST_SP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(acc && (req_op == 4'd7 || req_op == 4'd8))) |=> $stable(sp_out)); // R11

  AST_SP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    sp_out[DATA_W-1:ADDR_W] == '0); // R8

  AST_OVF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    sp_ovf |-> (sp_out == '0 && $past(sp_out) == DATA_W'((1 << ADDR_W) - 1))); // R8

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data))); // R10

  AST_NO_TAKE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready); // R10
endmodule

bind iram_core iram_core_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_data(rsp_data), .sp_out(sp_out), .sp_ovf(sp_ovf)
);

// File: tb/iram_core_test.sv
`timescale 1ns/1ps
module iram_core_test;
  import iram_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [3:0] req_op = 4'd0;
  logic [6:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic [1:0] bank_sel = '0;
  logic       rsp_valid;
  logic       rsp_ready = 1'b1;
  logic [7:0] rsp_data;
  logic [7:0] sp_out;
  logic       sp_ovf;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  iram_core uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .bank_sel(bank_sel), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .sp_out(sp_out), .sp_ovf(sp_ovf)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // called on a falling edge; returns result one edge after acceptance
  task automatic xact(input op_e op, input logic [6:0] a, input logic [7:0] d,
                      output logic [7:0] r);
    req_op = op; req_addr = a; req_wdata = d; req_valid = 1'b1; rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    r = rsp_data;
  endtask

  task automatic t_reset();
    logic [7:0] r;
    chk("R1", "sp after reset", sp_out, 8'h07);
    chk("R1", "rsp_valid after reset", rsp_valid, 0);
    chk("R1", "ovf after reset", sp_ovf, 0);
    xact(OP_WR_BYTE, 7'h05, 8'hAA, r);
    xact(OP_RD_REG, 7'd5, 8'h00, r);
    chk("R1", "bank 0 default R5", r, 8'hAA);
  endtask

  task automatic t_stack();
    logic [7:0] r;
    xact(OP_PUSH, 7'h00, 8'h3C, r);
    chk("R6", "first push sp", sp_out, 8'h08);
    chk("R6", "push echo", r, 8'h3C);
    xact(OP_PUSH, 7'h00, 8'h71, r);
    xact(OP_PUSH, 7'h00, 8'hD4, r);
    chk("R6", "sp after three", sp_out, 8'h0A);
    xact(OP_RD_BYTE, 7'h08, 8'h00, r);
    chk("R6", "mem 0x08", r, 8'h3C);
    xact(OP_RD_BYTE, 7'h0A, 8'h00, r);
    chk("R6", "mem 0x0A", r, 8'hD4);
    chk("R11", "sp after reads", sp_out, 8'h0A);
    xact(OP_POP, 7'h00, 8'h00, r);
    chk("R7", "pop 1", r, 8'hD4);
    chk("R7", "sp after pop 1", sp_out, 8'h09);
    xact(OP_POP, 7'h00, 8'h00, r);
    chk("R7", "pop 2", r, 8'h71);
    xact(OP_POP, 7'h00, 8'h00, r);
    chk("R7", "pop 3", r, 8'h3C);
    chk("R7", "sp back", sp_out, 8'h07);
  endtask

  task automatic t_bytes();
    logic [7:0] r;
    xact(OP_WR_BYTE, 7'h30, 8'h5A, r);
    chk("R2", "write echo", r, 8'h5A);
    xact(OP_WR_BYTE, 7'h7F, 8'hC3, r);
    xact(OP_WR_BYTE, 7'h00, 8'h19, r);
    xact(OP_RD_BYTE, 7'h30, 8'h00, r);
    chk("R2", "read 0x30", r, 8'h5A);
    xact(OP_RD_BYTE, 7'h7F, 8'h00, r);
    chk("R2", "read 0x7F", r, 8'hC3);
    xact(OP_RD_BYTE, 7'h00, 8'h00, r);
    chk("R2", "read 0x00", r, 8'h19);
  endtask

  task automatic t_regs();
    logic [7:0] r;
    bank_sel = 2'd2;
    xact(OP_BANK, 7'h00, 8'h00, r);
    chk("R3", "bank echo", r, 8'h02);
    xact(OP_WR_REG, 7'd3, 8'h11, r);
    xact(OP_RD_BYTE, 7'h13, 8'h00, r);
    chk("R3", "bank2 R3 at 0x13", r, 8'h11);
    bank_sel = 2'd3;
    xact(OP_BANK, 7'h00, 8'h00, r);
    xact(OP_WR_BYTE, 7'h1F, 8'h6E, r);
    xact(OP_RD_REG, 7'd7, 8'h00, r);
    chk("R3", "bank3 R7 from 0x1F", r, 8'h6E);
    bank_sel = 2'd0;
    xact(OP_BANK, 7'h00, 8'h00, r);
    xact(OP_RD_REG, 7'd5, 8'h00, r);
    chk("R3", "bank0 R5 again", r, 8'hAA);
  endtask

  task automatic t_bits();
    logic [7:0] r;
    xact(OP_WR_BYTE, 7'h24, 8'h00, r);
    xact(OP_BIT_SET, 7'h25, 8'h00, r);
    chk("R5", "set bit 0x25 result", r, 8'h20);
    xact(OP_RD_BYTE, 7'h24, 8'h00, r);
    chk("R4", "byte 0x24 after set", r, 8'h20);
    xact(OP_BIT_RD, 7'h25, 8'h00, r);
    chk("R4", "bit 0x25", r, 8'h01);
    xact(OP_BIT_RD, 7'h24, 8'h00, r);
    chk("R4", "bit 0x24", r, 8'h00);
    xact(OP_WR_BYTE, 7'h2F, 8'hFF, r);
    xact(OP_BIT_CLR, 7'h7F, 8'h00, r);
    chk("R5", "clear bit 0x7F result", r, 8'h7F);
    xact(OP_WR_BYTE, 7'h20, 8'h80, r);
    xact(OP_BIT_SET, 7'h00, 8'h00, r);
    xact(OP_RD_BYTE, 7'h20, 8'h00, r);
    chk("R5", "byte 0x20 after set bit 0", r, 8'h81);
  endtask

  task automatic t_unused();
    logic [7:0] r;
    xact(OP_WR_BYTE, 7'h45, 8'h9B, r);
    req_op = 4'd12; req_addr = 7'h45; req_wdata = 8'h00; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9", "unused op result", rsp_data, 8'h00);
    chk("R9", "unused op sp", sp_out, 8'h07);
    xact(OP_RD_BYTE, 7'h45, 8'h00, r);
    chk("R9", "byte after unused op", r, 8'h9B);
  endtask

  task automatic t_stall();
    logic [7:0] r;
    logic [7:0] held;
    xact(OP_WR_BYTE, 7'h31, 8'h4D, r);
    req_op = OP_RD_BYTE; req_addr = 7'h31; req_valid = 1'b1; rsp_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    held = rsp_data;
    chk("R10", "stalled data", held, 8'h4D);
    req_op = OP_PUSH; req_wdata = 8'h99;
    for (int i = 0; i < 3; i++) begin
      chk("R10", "ready low while held", req_ready, 0);
      chk("R10", "valid held", rsp_valid, 1);
      chk("R10", "data held", rsp_data, held);
      chk("R10", "push not taken", sp_out, 8'h07);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10", "queued push result", rsp_data, 8'h99);
    chk("R10", "queued push sp", sp_out, 8'h08);
    xact(OP_POP, 7'h00, 8'h00, r);
  endtask

  task automatic t_wrap();
    logic [7:0] r;
    for (int i = 0; i < 120; i++) xact(OP_PUSH, 7'h00, 8'(i), r);
    chk("R8", "sp at top", sp_out, 8'h7F);
    chk("R8", "no ovf before top", sp_ovf, 0);
    xact(OP_PUSH, 7'h00, 8'hEE, r);
    chk("R8", "ovf pulse", sp_ovf, 1);
    chk("R8", "sp wrapped", sp_out, 8'h00);
    xact(OP_RD_BYTE, 7'h00, 8'h00, r);
    chk("R8", "ovf one cycle", sp_ovf, 0);
    chk("R8", "wrapped push at 0x00", r, 8'hEE);
    xact(OP_POP, 7'h00, 8'h00, r);
    chk("R8", "pop at 0x00", r, 8'hEE);
    chk("R8", "sp after underflow", sp_out, 8'h7F);
    chk("R8", "no ovf on pop", sp_ovf, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stack();
    t_bytes();
    t_regs();
    t_bits();
    t_unused();
    t_stall();
    t_wrap();
    finished = 1;
  end

  initial begin
    fork
      begin
        wait (finished);
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule